// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Status Flags

This block combines a 16-bit arithmetic and logic unit with a 16-bit status register. On every clock edge where an operation strobe is high, it takes two operands and an operation code. It registers the result and, when flag updating is enabled, records carry, zero, negative and overflow in the status register. The same register also holds an interrupt-enable bit and four power-control bits. These five bits are changed only by a direct register write.

Subtraction follows the not-borrow convention: carry ends up set when the subtraction needed no borrow. A compare runs the subtraction for its flags only and throws the difference away. Unsigned ordering is then read from carry and zero, and signed ordering from negative XOR overflow. A move copies an operand and never touches the flags.

Top module: `arith_flag_unit`

## Requirements
- R1: While reset is asserted and after it is released, `result` and `statusOut` are both zero.
- R2: Opcode 0 (add) registers A+B and opcode 1 (add with carry) registers A+B+C. With flag updating on, C takes bit 16 of the sum, Z is set when the result is zero and N takes result bit 15.
- R3: Opcode 2 (subtract) registers A+~B+1 and opcode 3 (subtract with borrow) registers A+~B+C. C is set when no borrow occurred (A ≥ B plus any borrow), and Z and N follow the result.
- R4: V is set on an add when both addends share a sign that the result does not. V is set on a subtract when the operands differ in sign and the result's sign differs from A's.
- R5: Opcode 4 (compare) sets C, Z, N and V exactly as a subtract of B from A would, while `result` keeps its previous value.
- R6: Opcodes 5, 6 and 7 register A AND B, A OR B and A XOR B. With flag updating on, Z and N follow the result, C is the inverse of Z and V is cleared.
- R7: Opcode 8 (move) registers B and leaves every status bit unchanged, even with flag updating on.
- R8: With `flagEn` low, any operation still registers its result but leaves the status register unchanged.
- R9: With `srWrEn` high, bits 8..0 of `srWrData` load the status register and bits 15..9 read as zero. The bit positions are C=0, Z=1, N=2, GIE=3, CPUOFF=4, OSCOFF=5, SCG0=6, SCG1=7, V=8. This write wins over a flag update in the same cycle.
- R10: Bits 7..3 (interrupt enable and power control) change only through a direct write, never through an operation.
- R11: With `opGo` low, or with an opcode from 9 to 15, neither `result` nor the status register changes.
- R12: Results and flags appear on the clock edge that samples the operation, and carry-in is the C value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opGo | input | 1 | Execute the operation on this edge |
| opSel | input | 4 | Operation code |
| opA | input | 16 | First operand (minuend) |
| opB | input | 16 | Second operand (subtrahend / move source) |
| flagEn | input | 1 | Allow arithmetic/logic ops to update C, Z, N, V |
| srWrEn | input | 1 | Direct status register write |
| srWrData | input | 16 | Data for the direct write |
| result | output | 16 | Registered operation result |
| statusOut | output | 16 | Status register contents |

## Verification
Every operation or write is due exactly one clock edge after its inputs are presented. Both `result` and `statusOut` reflect it just after that edge. The driver presents inputs on the falling edge and queues the expected result and status. The monitor pops one entry two nanoseconds after each following rising edge, so each comparison lands in the cycle its result becomes valid. Back-to-back operations check that the carry chained into add-with-carry and subtract-with-borrow comes from the previous edge.

// File: rtl/afu_pkg.sv
package afu_pkg;
  localparam int OP_W = 4;
  localparam int SR_W = 16;

  localparam int BIT_C      = 0;
  localparam int BIT_Z      = 1;
  localparam int BIT_N      = 2;
  localparam int BIT_GIE    = 3;
  localparam int BIT_CPUOFF = 4;
  localparam int BIT_OSCOFF = 5;
  localparam int BIT_SCG0   = 6;
  localparam int BIT_SCG1   = 7;
  localparam int BIT_V      = 8;
  localparam logic [SR_W-1:0] SR_MASK = 16'h01FF;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_CMP  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_MOV  = 4'd8
  } opCode_e;

  typedef enum logic [2:0] {
    SEL_SUM = 3'd0,
    SEL_AND = 3'd1,
    SEL_OR  = 3'd2,
    SEL_XOR = 3'd3,
    SEL_B   = 3'd4
  } resSel_e;

  typedef struct packed {
    logic    loadRes;
    logic    updFlags;
    logic    invertB;
    logic    useCarryIn;
    logic    forceCin;
    resSel_e resSel;
  } aluStrobe_t;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } flagVec_t;
endpackage

// File: rtl/afu_ctrl.sv
module afu_ctrl
  import afu_pkg::*;
(
  input  logic            opGo,
  input  logic [OP_W-1:0] opSel,
  input  logic            flagEn,
  output aluStrobe_t      strb
);
  always_comb begin
    strb = '0;
    strb.resSel = SEL_SUM;
    if (opGo) begin
      case (opSel)
        OP_ADD: begin
          strb.loadRes  = 1'b1;
          strb.updFlags = flagEn;
        end
        OP_ADDC: begin
          strb.loadRes    = 1'b1;
          strb.updFlags   = flagEn;
          strb.useCarryIn = 1'b1;
        end
        OP_SUB: begin
          strb.loadRes  = 1'b1;
          strb.updFlags = flagEn;
          strb.invertB  = 1'b1;
          strb.forceCin = 1'b1;
        end
        OP_SUBC: begin
          strb.loadRes    = 1'b1;
          strb.updFlags   = flagEn;
          strb.invertB    = 1'b1;
          strb.useCarryIn = 1'b1;
        end
        OP_CMP: begin
          strb.updFlags = flagEn;
          strb.invertB  = 1'b1;
          strb.forceCin = 1'b1;
        end
        OP_AND: begin
          strb.loadRes  = 1'b1;
          strb.updFlags = flagEn;
          strb.resSel   = SEL_AND;
        end
        OP_OR: begin
          strb.loadRes  = 1'b1;
          strb.updFlags = flagEn;
          strb.resSel   = SEL_OR;
        end
        OP_XOR: begin
          strb.loadRes  = 1'b1;
          strb.updFlags = flagEn;
          strb.resSel   = SEL_XOR;
        end
        OP_MOV: begin
          strb.loadRes = 1'b1;
          strb.resSel  = SEL_B;
        end
        default: strb = '0;
      endcase
    end
  end
endmodule

// File: rtl/afu_datapath.sv
module afu_datapath
  import afu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  aluStrobe_t   strb,
  input  logic         carryIn,
  output logic [W-1:0] resQ,
  output flagVec_t     newFlags
);
  localparam int MSB = W - 1;

  logic [W-1:0] bEff;
  logic         cinEff;
  logic [W:0]   sumWide;
  logic [W-1:0] resNext;

  always_comb begin
    bEff    = strb.invertB ? ~opB : opB;
    cinEff  = strb.useCarryIn ? carryIn : strb.forceCin;
    sumWide = {1'b0, opA} + {1'b0, bEff} + {{W{1'b0}}, cinEff};
  end

  always_comb begin
    case (strb.resSel)
      SEL_AND: resNext = opA & opB;
      SEL_OR:  resNext = opA | opB;
      SEL_XOR: resNext = opA ^ opB;
      SEL_B:   resNext = opB;
      default: resNext = sumWide[W-1:0];
    endcase
  end

  always_comb begin
    newFlags.z = (resNext == '0);
    newFlags.n = resNext[MSB];
    if (strb.resSel == SEL_SUM) begin
      newFlags.c = sumWide[W];
      newFlags.v = (opA[MSB] == bEff[MSB]) && (resNext[MSB] != opA[MSB]);
    end else begin
      newFlags.c = ~newFlags.z;
      newFlags.v = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             resQ <= '0;
    else if (strb.loadRes) resQ <= resNext;
  end
endmodule

// File: rtl/afu_status.sv
module afu_status
  import afu_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [SR_W-1:0] wrData,
  input  logic            updFlags,
  input  flagVec_t        newFlags,
  output logic [SR_W-1:0] srQ
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srQ <= '0;
    end else if (wrEn) begin
      srQ <= wrData & SR_MASK;
    end else if (updFlags) begin
      srQ[BIT_C] <= newFlags.c;
      srQ[BIT_Z] <= newFlags.z;
      srQ[BIT_N] <= newFlags.n;
      srQ[BIT_V] <= newFlags.v;
    end
  end

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> srQ == ($past(wrData) & SR_MASK));

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    srQ[SR_W-1:BIT_V+1] == '0);

  assert_ctrl_bits_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(srQ[BIT_SCG1:BIT_GIE]));

  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !updFlags) |=> $stable(srQ));
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import afu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opGo,
  input  logic [3:0]  opSel,
  input  logic [15:0] opA,
  input  logic [15:0] opB,
  input  logic        flagEn,
  input  logic        srWrEn,
  input  logic [15:0] srWrData,
  output logic [15:0] result,
  output logic [15:0] statusOut
);
  aluStrobe_t strb;
  flagVec_t   newFlags;

  afu_ctrl ctrl_i (
    .opGo   (opGo),
    .opSel  (opSel),
    .flagEn (flagEn),
    .strb   (strb)
  );

  afu_datapath #(.W(16)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .opA      (opA),
    .opB      (opB),
    .strb     (strb),
    .carryIn  (statusOut[BIT_C]),
    .resQ     (result),
    .newFlags (newFlags)
  );

  afu_status sr_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (srWrEn),
    .wrData   (srWrData),
    .updFlags (strb.updFlags),
    .newFlags (newFlags),
    .srQ      (statusOut)
  );

  assert_logic_flags_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opGo && flagEn && !srWrEn && opSel >= 4'd5 && opSel <= 4'd7)
      |=> (statusOut[BIT_C] == !statusOut[BIT_Z]) && !statusOut[BIT_V]);

  assert_zero_tracks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (opGo && flagEn && !srWrEn && opSel <= 4'd3)
      |=> statusOut[BIT_Z] == (result == 16'h0000));

  assert_move_keeps_flags_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opGo && !srWrEn && opSel == 4'd8) |=> $stable(statusOut));
endmodule

// File: tb/arith_flag_unit_tb_top.sv
`timescale 1ns/1ps
module arith_flag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opGo = 1'b0;
  logic [3:0]  opSel = '0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic        flagEn = 1'b0;
  logic        srWrEn = 1'b0;
  logic [15:0] srWrData = '0;
  logic [15:0] result;
  logic [15:0] statusOut;

  always #4 clk = ~clk;

  arith_flag_unit dut_i (
    .clk(clk), .rstN(rstN), .opGo(opGo), .opSel(opSel), .opA(opA), .opB(opB),
    .flagEn(flagEn), .srWrEn(srWrEn), .srWrData(srWrData),
    .result(result), .statusOut(statusOut)
  );

  typedef struct {
    logic [15:0] res;
    logic [15:0] sr;
    string       tag;
  } expItem_t;

  expItem_t    sbq[$];
  int          checks = 0;
  int          errors = 0;
  logic [15:0] mRes = '0;
  logic [15:0] mSr = '0;
  bit          done = 1'b0;

  task automatic check16(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Driver: presents one operation on a falling edge and queues its expected outcome.
  task automatic doOp(input logic go, input logic [3:0] op, input logic [15:0] a,
                      input logic [15:0] b, input logic fe, input logic wr,
                      input logic [15:0] wd, input string tag);
    int ua, ub, sa, sb, full, sfull, cin;
    logic [15:0] val;
    logic ld, upd, nc, nv;
    @(negedge clk);
    opGo = go; opSel = op; opA = a; opB = b; flagEn = fe; srWrEn = wr; srWrData = wd;
    ua = a; ub = b; sa = $signed(a); sb = $signed(b);
    ld = 1'b0; upd = 1'b0; nc = 1'b0; nv = 1'b0; val = 16'h0;
    if (go) begin
      if (op == 4'd0 || op == 4'd1) begin
        cin = (op == 4'd1) ? int'(mSr[0]) : 0;
        full = ua + ub + cin; sfull = sa + sb + cin;
        val = full[15:0]; nc = full > 65535; nv = (sfull > 32767) || (sfull < -32768);
        ld = 1'b1; upd = fe;
      end else if (op >= 4'd2 && op <= 4'd4) begin
        cin = (op == 4'd3) ? int'(!mSr[0]) : 0;
        full = ua - ub - cin; sfull = sa - sb - cin;
        val = full[15:0]; nc = full >= 0; nv = (sfull > 32767) || (sfull < -32768);
        ld = (op != 4'd4); upd = fe;
      end else if (op >= 4'd5 && op <= 4'd7) begin
        val = (op == 4'd5) ? (a & b) : (op == 4'd6) ? (a | b) : (a ^ b);
        nc = (val != 16'h0); nv = 1'b0;
        ld = 1'b1; upd = fe;
      end else if (op == 4'd8) begin
        val = b; ld = 1'b1;
      end
    end
    if (ld) mRes = val;
    if (wr) mSr = {7'b0, wd[8:0]};
    else if (upd) begin
      mSr[0] = nc; mSr[1] = (val == 16'h0); mSr[2] = val[15]; mSr[8] = nv;
    end
    sbq.push_back('{res: mRes, sr: mSr, tag: tag});
  endtask

  task automatic idle();
    @(negedge clk);
    opGo = 1'b0; srWrEn = 1'b0; flagEn = 1'b0;
  endtask

  // Monitor: each item is due just after the rising edge that follows its drive.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        expItem_t it;
        it = sbq.pop_front();
        check16({it.tag, " result"}, result, it.res);
        check16({it.tag, " status"}, statusOut, it.sr);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check16("R1 reset result", result, 16'h0);
    check16("R1 reset status", statusOut, 16'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check16("R1 post-reset status", statusOut, 16'h0);

    doOp(1, 4'd0, 16'h1234, 16'h1111, 1, 0, 0, "R2 add plain");
    doOp(1, 4'd0, 16'hFFFF, 16'h0001, 1, 0, 0, "R2 add carry zero");
    doOp(1, 4'd1, 16'h0005, 16'h0006, 1, 0, 0, "R12 addc chained carry");
    doOp(1, 4'd0, 16'h7FFF, 16'h0001, 1, 0, 0, "R4 add overflow");
    doOp(1, 4'd0, 16'h8000, 16'h8000, 1, 0, 0, "R4 add neg overflow");
    doOp(1, 4'd1, 16'h0100, 16'h0001, 1, 0, 0, "R2 addc carry in");
    doOp(1, 4'd2, 16'h0005, 16'h0003, 1, 0, 0, "R3 sub no borrow");
    doOp(1, 4'd2, 16'h0003, 16'h0005, 1, 0, 0, "R3 sub borrow");
    doOp(1, 4'd3, 16'h000A, 16'h0003, 1, 0, 0, "R3 subc with borrow");
    doOp(1, 4'd3, 16'h000A, 16'h0003, 1, 0, 0, "R3 subc no borrow");
    doOp(1, 4'd2, 16'h8000, 16'h0001, 1, 0, 0, "R4 sub overflow");
    doOp(1, 4'd4, 16'h4444, 16'h4444, 1, 0, 0, "R5 cmp equal");
    doOp(1, 4'd4, 16'h0002, 16'h0009, 1, 0, 0, "R5 cmp below");
    doOp(1, 4'd4, 16'hFFFE, 16'h0001, 1, 0, 0, "R5 cmp signed");
    doOp(1, 4'd5, 16'hF0F0, 16'h0F0F, 1, 0, 0, "R6 and zero");
    doOp(1, 4'd6, 16'h8000, 16'h0001, 1, 0, 0, "R6 or negative");
    doOp(1, 4'd7, 16'h1234, 16'h1230, 1, 0, 0, "R6 xor");
    doOp(1, 4'd8, 16'h0000, 16'h0000, 1, 0, 0, "R7 move zero");
    doOp(1, 4'd0, 16'hFFFF, 16'h0001, 0, 0, 0, "R8 add flags off");
    doOp(1, 4'd2, 16'h0001, 16'h0002, 0, 0, 0, "R8 sub flags off");
    doOp(1, 4'd0, 16'h0000, 16'h0000, 1, 1, 16'hFFFF, "R9 write masked wins");
    doOp(1, 4'd8, 16'h0000, 16'hABCD, 1, 0, 0, "R7 move keeps flags");
    doOp(1, 4'd5, 16'h0000, 16'h0000, 1, 0, 0, "R10 logic keeps ctrl bits");
    doOp(1, 4'd2, 16'h0001, 16'h0003, 1, 0, 0, "R10 sub keeps ctrl bits");
    doOp(0, 4'd0, 16'h1111, 16'h1111, 1, 0, 0, "R11 no go");
    doOp(1, 4'd12, 16'h1111, 16'h1111, 1, 0, 0, "R11 bad opcode");
    doOp(0, 4'd0, 16'h0000, 16'h0000, 0, 1, 16'h0028, "R9 write only");
    doOp(1, 4'd15, 16'h0000, 16'h0000, 1, 1, 16'h0000, "R9 write clears");
    for (int i = 0; i < 400; i++) begin
      logic [3:0] rop;
      rop = 4'($urandom_range(0, 9));
      doOp(1'($urandom_range(0, 9) != 0), rop, 16'($urandom), 16'($urandom),
           1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 15) == 0),
           16'($urandom), "R12 random mix");
    end
    idle();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule